// File: doc/BRIEF.md
# Compare-Match Event Timer

This block is an 8-bit up-counter driven by a selectable count source. The source is one of several prescaler taps, or an external event line that is first synchronized. The counter value is compared continuously against a compare register that software may rewrite at any time. When they meet, the block raises a one-cycle interrupt and updates a timer output pin.

Software sets up the block through a small write bus with three targets: control, source select and compare. A control bit enables counting. Clearing it returns the counter to zero. A second control bit picks the mode. In the clear-and-start (interval) mode a match restarts the count and toggles the output. In the PWM mode the counter runs through the full 8-bit range, and the output is high below the compare value and low from there to the wrap.

The counter value is always visible on the read port. While a read hold is asserted, count edges are deferred, so that a multi-cycle read sees a stable value. One deferred edge is applied after the hold ends.

Top module: `evt_timer8`

## Requirements
- R1: While enabled with a source select of 0 to 3, each rising edge of presc_tap[select] adds one to the counter, visible on rd_data one clock after the edge is seen. Edges on the other taps have no effect.
- R2: While rd_hold is high the counter does not change. If one or more count edges arrive during the hold, exactly one increment is applied on the first clock after rd_hold falls.
- R3: After reset, and at every clock while the enable bit is 0, the counter reads 00h and irq and tmr_out are 0.
- R4: In interval mode (control bit 1 = 0), a count edge taken while the counter equals the compare value sets the counter to 00h. In that same clock, irq goes high for exactly one clock. The period is therefore compare+1 edges.
- R5: In PWM mode (control bit 1 = 1), irq never rises, and the counter wraps from FFh to 00h regardless of the compare value.
- R6: In PWM mode, tmr_out is 1 while the counter is below the compare value and 0 otherwise.
- R7: In interval mode, tmr_out starts at 0 on enabling and toggles on every match.
- R8: Any source select of 4 or more counts rising edges of ext_evt, taken through a two-flop synchronizer. An edge driven before clock k shows on rd_data after clock k+2.
- R9: The compare register accepts any value from 00h to FFh while counting. With compare 00h, every edge matches. A compare value written below the current count is reached only after the counter wraps through FFh.
- R10: A write with wr_en high targets wr_addr 0 (control: bit 0 enable, bit 1 mode), 1 (source select, bits 2:0) or 2 (compare, 8 bits), and takes effect at that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write target |
| wr_data | input | 8 | Register write data |
| rd_hold | input | 1 | Read hold; defers count edges |
| rd_data | output | 8 | Current counter value |
| ext_evt | input | 1 | Asynchronous external event line |
| presc_tap | input | 4 | Prescaler tap levels, synchronous to clk |
| irq | output | 1 | Match interrupt pulse |
| tmr_out | output | 1 | Timer output pin level |

## Verification
The read hold and a count edge can land in the same cycle. The bench pulses the selected tap several times while rd_hold is high. It judges that the counter stays frozen throughout, and that only a single increment appears on the clock after the hold drops. A match and a compare rewrite can also meet: the compare value is lowered beneath a running count, and the bench expects no interrupt until the counter has wrapped and climbed back to the new value.

// File: rtl/evt_timer8_pkg.sv
package evt_timer8_pkg;

    localparam int CNT_W = 8;
    localparam int NTAP  = 4;
    localparam int SEL_W = $clog2(NTAP) + 1;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CSEL = 2'd1,
        ADDR_CMP  = 2'd2
    } addr_e;

    typedef enum logic {
        MODE_CLRST = 1'b0,
        MODE_PWM   = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  en;
    } ctrl_t;

    function automatic logic is_ext(input logic [SEL_W-1:0] s);
        return s >= SEL_W'(NTAP);
    endfunction

endpackage

// File: rtl/evt_tick_src.sv
module evt_tick_src #(
    parameter int NTAP  = evt_timer8_pkg::NTAP,
    parameter int SEL_W = evt_timer8_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic [NTAP-1:0]  taps,
    input  logic             ext,
    output logic             tick
);
    localparam int TAP_W = (NTAP > 1) ? $clog2(NTAP) : 1;

    logic s1, s2;
    logic lvl, lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            lvl_q <= 1'b0;
        end else begin
            s1    <= ext;
            s2    <= s1;
            lvl_q <= lvl;
        end
    end

    always_comb begin
        if (evt_timer8_pkg::is_ext(sel)) lvl = s2;
        else                             lvl = taps[sel[TAP_W-1:0]];
    end

    assign tick = lvl & ~lvl_q;

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
    parameter int CNT_W = evt_timer8_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             pwm,
    input  logic             tick,
    input  logic             hold,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    logic pend, step, eq;

    assign eq   = (cnt == cmp);
    assign step = en & ~hold & (tick | pend);
    assign hit  = step & eq & ~pwm;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            pend <= hold ? (pend | tick) : (pend & tick);
            if (step) begin
                if (hit) cnt <= '0;
                else     cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/evt_out_gen.sv
module evt_out_gen #(
    parameter int CNT_W = evt_timer8_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             pwm,
    input  logic             hit,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             irq,
    output logic             tmr_out
);
    logic tgl;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
            tgl <= 1'b0;
        end else begin
            irq <= hit;
            tgl <= en ? (tgl ^ hit) : 1'b0;
        end
    end

    assign tmr_out = pwm ? (en & (cnt < cmp)) : tgl;

endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
    import evt_timer8_pkg::*;
#(
    parameter int CNT_W = evt_timer8_pkg::CNT_W,
    parameter int NTAP  = evt_timer8_pkg::NTAP,
    parameter int SEL_W = evt_timer8_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_hold,
    output logic [CNT_W-1:0] rd_data,
    input  logic             ext_evt,
    input  logic [NTAP-1:0]  presc_tap,
    output logic             irq,
    output logic             tmr_out
);
    ctrl_t            ctrl_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cmp_q;
    logic             tick, hit, pwm;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{mode: MODE_CLRST, en: 1'b0};
            sel_q  <= '0;
            cmp_q  <= '0;
        end else if (wr_en) begin
            case (addr_e'(wr_addr))
                ADDR_CTRL: ctrl_q <= '{mode: mode_e'(wr_data[1]), en: wr_data[0]};
                ADDR_CSEL: sel_q  <= wr_data[SEL_W-1:0];
                ADDR_CMP:  cmp_q  <= wr_data;
                default: ;
            endcase
        end
    end

    assign pwm = (ctrl_q.mode == MODE_PWM);

    evt_tick_src #(.NTAP(NTAP), .SEL_W(SEL_W)) u_src (
        .clk(clk), .rst(rst), .sel(sel_q), .taps(presc_tap),
        .ext(ext_evt), .tick(tick)
    );

    evt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .en(ctrl_q.en), .pwm(pwm), .tick(tick),
        .hold(rd_hold), .cmp(cmp_q), .cnt(cnt), .hit(hit)
    );

    evt_out_gen #(.CNT_W(CNT_W)) u_out (
        .clk(clk), .rst(rst), .en(ctrl_q.en), .pwm(pwm), .hit(hit),
        .cnt(cnt), .cmp(cmp_q), .irq(irq), .tmr_out(tmr_out)
    );

    assign rd_data = cnt;

endmodule

// File: rtl/evt_timer8_chk.sv
module evt_timer8_chk #(
    parameter int CNT_W = evt_timer8_pkg::CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             pwm,
    input logic             rd_hold,
    input logic [CNT_W-1:0] rd_data,
    input logic             irq,
    input logic             tmr_out
);
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (rd_hold && en) |=> (rd_data == $past(rd_data))); // R2
    AST_OFF_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !en |=> (rd_data == '0)); // R3
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(en)); // R3
    AST_OFF_OUT_LOW: assert property (@(posedge clk) disable iff (rst)
        (!en && $past(!en)) |-> !tmr_out); // R3
    AST_CLEAR_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rd_data == '0)); // R4
    AST_PWM_SILENT: assert property (@(posedge clk) disable iff (rst)
        $past(pwm) |-> !irq); // R5
endmodule

bind evt_timer8 evt_timer8_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .en(ctrl_q.en), .pwm(pwm), .rd_hold(rd_hold),
    .rd_data(rd_data), .irq(irq), .tmr_out(tmr_out)
);

// File: tb/evt_timer8_bench.sv
module evt_timer8_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       rd_hold = 1'b0;
    logic [7:0] rd_data;
    logic       ext_evt = 1'b0;
    logic [3:0] presc_tap = 4'd0;
    logic       irq, tmr_out;

    int nchk = 0;
    int nfail = 0;
    int irqs;
    bit done = 0;

    always #10 clk = ~clk;

    evt_timer8 u_evt_timer8 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_hold(rd_hold), .rd_data(rd_data),
        .ext_evt(ext_evt), .presc_tap(presc_tap), .irq(irq), .tmr_out(tmr_out)
    );

    // {compare, edges, expected count, expected irq count}, interval mode, tap 0
    localparam logic [31:0] VEC [6] = '{
        {8'd5,   8'd3,  8'd3,  8'd0},
        {8'd5,   8'd6,  8'd0,  8'd1},
        {8'd2,   8'd7,  8'd1,  8'd2},
        {8'd0,   8'd4,  8'd0,  8'd4},
        {8'hFF,  8'd10, 8'd10, 8'd0},
        {8'd1,   8'd5,  8'd1,  8'd2}
    };

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        presc_tap[idx] = 1'b1;
        @(negedge clk);
        presc_tap[idx] = 1'b0;
        if (irq) irqs++;
    endtask

    task automatic pulses(input int idx, input int n);
        for (int k = 0; k < n; k++) pulse(idx);
    endtask

    task automatic disable_tmr();
        wr(2'd0, 8'h00);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] vc, vn, ve, vi;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 reset count", rd_data, 0);
        chk("R3 reset irq", irq, 0);
        chk("R3 reset tmr_out", tmr_out, 0);

        // table walk: interval mode periods, irq counts, output toggling
        for (int v = 0; v < 6; v++) begin
            {vc, vn, ve, vi} = VEC[v];
            disable_tmr();
            wr(2'd2, vc);
            wr(2'd1, 8'd0);
            wr(2'd0, 8'h01);
            irqs = 0;
            pulses(0, vn);
            chk("R4 count after edges", rd_data, ve);
            chk("R9 irq count", irqs, vi);
            chk("R7 tmr_out parity", tmr_out, vi[0]);
        end

        // irq width with compare 0 (R4)
        disable_tmr();
        wr(2'd2, 8'd0); wr(2'd0, 8'h01);
        irqs = 0;
        pulse(0);
        chk("R4 irq high on match", irqs, 1);
        @(negedge clk);
        chk("R4 irq one cycle", irq, 0);

        // disable clears (R3)
        disable_tmr();
        wr(2'd2, 8'hFF); wr(2'd0, 8'h01);
        pulses(0, 5);
        chk("R1 five edges", rd_data, 5);
        disable_tmr();
        chk("R3 disable clears", rd_data, 0);
        pulse(0);
        chk("R3 no count when off", rd_data, 0);

        // tap selection (R1)
        wr(2'd1, 8'd2); wr(2'd0, 8'h01);
        pulses(1, 2);
        chk("R1 other tap ignored", rd_data, 0);
        pulses(2, 3);
        chk("R1 selected tap counts", rd_data, 3);

        // read hold with edges inside (R2)
        rd_hold = 1'b1;
        pulses(2, 3);
        chk("R2 frozen during hold", rd_data, 3);
        @(negedge clk);
        rd_hold = 1'b0;
        @(negedge clk);
        chk("R2 one deferred edge applied", rd_data, 4);
        repeat (3) @(negedge clk);
        chk("R2 no extra edges", rd_data, 4);

        // external event (R8)
        wr(2'd1, 8'd4);
        @(negedge clk);
        ext_evt = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 not yet after two clocks", rd_data, 4);
        @(negedge clk);
        chk("R8 counted after three clocks", rd_data, 5);
        ext_evt = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 single edge", rd_data, 5);

        // compare written below running count (R9)
        disable_tmr();
        wr(2'd1, 8'd0); wr(2'd2, 8'hFF); wr(2'd0, 8'h01);
        pulses(0, 10);
        wr(2'd2, 8'd3);
        irqs = 0;
        pulses(0, 249);
        chk("R9 reached after wrap", rd_data, 3);
        chk("R9 no early irq", irqs, 0);
        pulse(0);
        chk("R9 match after wrap", irqs, 1);
        chk("R10 compare write effective", rd_data, 0);

        // PWM mode (R5, R6)
        disable_tmr();
        wr(2'd2, 8'd3); wr(2'd0, 8'h03);
        @(negedge clk);
        chk("R6 high below compare", tmr_out, 1);
        irqs = 0;
        pulses(0, 3);
        chk("R6 low at compare", tmr_out, 0);
        chk("R5 counter passes compare", rd_data, 3);
        pulses(0, 253);
        chk("R5 wrapped to zero", rd_data, 0);
        chk("R5 no irq in PWM", irqs, 0);
        chk("R6 high after wrap", tmr_out, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule